// File: doc/BRIEF.md
# Decimated Phase-Error Lock Detector

This block decides whether a phase-locked loop is in lock by timing the gap between the rising edges of the divided reference and the divided feedback signals. A fast measurement clock counts that gap. A measurement is taken on every pair of edges, but only one completed measurement in every `DECIM` (64 by default) is passed to the decision filter.

The filter uses two different limits. A tight acquire threshold must be met on `GOOD_NEEDED` (4) evaluated comparisons in a row before the lock output rises. The tight threshold is selectable by band: 5 counts for the high band and 10 counts for the low band. A looser loss threshold of 10 counts in both bands drops lock after one evaluated comparison that exceeds it. A width between the two thresholds keeps an existing lock but restarts the run of good comparisons.

The lock output is registered. It is held low while the enable bit is clear or while the synthesizer is powered down. Power-down also wipes every piece of lock history.

Top module: `pll_lock_filter`

## Requirements
- R1: Only every `DECIM`-th completed measurement (64 by default), counted from reset or from the end of power-down, is evaluated; the other measurements leave the lock state unchanged.
- R2: Lock rises after `GOOD_NEEDED` (4) consecutive evaluated comparisons that are each good; after three such comparisons the output is still low.
- R3: A comparison is good when its width is strictly below the acquire threshold. That threshold is `ACQ_THR_HI` (5) when `band_high`=1 and `ACQ_THR_LO` (10) when `band_high`=0, so a width equal to the threshold is not good.
- R4: While locked, one evaluated width greater than `LOSS_THR` (10) drops lock; an evaluated width of at most 10 keeps lock.
- R5: Any evaluated comparison that is not good resets the run of consecutive good comparisons to zero.
- R6: Width is measured in fast-clock cycles from the first rising edge of either input to the rising edge of the other input, whichever input leads. Rising edges in the same cycle give a width of 0. If the leading input rises again before the lagging one rises, the measurement is reported at the saturated width 2^`CNT_W`-1, which counts as bad.
- R7: When `ld_enable`=0, `lock_out` is low one cycle later, and the internal lock state is kept. When `ld_enable` returns to 1, `lock_out` shows the kept state again one cycle later.
- R8: `power_down`=1 forces `lock_out` low and clears the lock flag, the run of good comparisons, the decimation phase and any measurement in progress.
- R9: After reset `lock_out` is 0. `lock_out` is a register that follows the internal lock state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_div | input | 1 | Divided reference level (asynchronous to clk) |
| fb_div | input | 1 | Divided feedback level (asynchronous to clk) |
| ld_enable | input | 1 | Lock output enable; 0 forces the output low |
| power_down | input | 1 | Synthesizer power-down; clears all lock state |
| band_high | input | 1 | Selects the tight acquire threshold (1) or the relaxed one (0) |
| lock_out | output | 1 | Registered lock indication |

## Verification
The assertions check the following on every cycle:
- Lock can rise only on an evaluation strobe whose width was good.
- Lock can fall only through power-down or an evaluated width above the loss threshold.
- The good-comparison counter stays within its bound.
- Evaluation strobes are isolated single-cycle pulses.
- Edges in the same cycle yield a zero width.
- The output is low in the cycle after the enable bit is clear.

Some behaviours can only be shown by the bench scenarios, because they span hundreds of reference periods:
- The exact count of comparisons needed to lock.
- The decimation phase, where 63 bad pairs are ignored and the 64th is not.
- The threshold boundaries in each band.
- The reset of the good-comparison run by a mid-range width.
- The handling of a missing feedback edge.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  // Which input rose first in the current measurement
  typedef enum logic {
    LEAD_REF = 1'b0,
    LEAD_FB  = 1'b1
  } lead_e;

  // Channel indices inside the synchronizer bundle
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;
  localparam int unsigned CH_NUM = 2;

endpackage

// File: rtl/lkd_edge_sync.sv
module lkd_edge_sync #(
  parameter int unsigned CHANNELS    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] lvl_i,
  output logic [CHANNELS-1:0] rise_o
);

  // chain[0] is the first capture stage; chain[SYNC_STAGES] is the previous synced value
  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-1:0], lvl_i[g]};
    end

    assign rise_o[g] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  end

endmodule

// File: rtl/lkd_phase_meter.sv
module lkd_phase_meter
  import lkd_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             rise_ref_i,
  input  logic             rise_fb_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] width_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             busy;
  lead_e            lead;
  logic [CNT_W-1:0] cnt;
  logic             lead_rise;
  logic             lag_rise;

  assign lead_rise = (lead == LEAD_REF) ? rise_ref_i : rise_fb_i;
  assign lag_rise  = (lead == LEAD_REF) ? rise_fb_i  : rise_ref_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      busy    <= 1'b0;
      lead    <= LEAD_REF;
      cnt     <= '0;
      valid_o <= 1'b0;
      width_o <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!busy) begin
        if (rise_ref_i && rise_fb_i) begin
          valid_o <= 1'b1;
          width_o <= '0;
        end else if (rise_ref_i || rise_fb_i) begin
          busy <= 1'b1;
          lead <= rise_ref_i ? LEAD_REF : LEAD_FB;
          cnt  <= CNT_W'(1);
        end
      end else begin
        if (lag_rise) begin
          valid_o <= 1'b1;
          width_o <= cnt;
          busy    <= 1'b0;
        end else if (lead_rise) begin
          // lagging edge never arrived: report as saturated and restart
          valid_o <= 1'b1;
          width_o <= CNT_MAX;
          cnt     <= CNT_W'(1);
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R6: same-cycle edges from idle give a zero-width result next cycle
  p_coincident_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !clr_i && rise_ref_i && rise_fb_i) |=> (valid_o && width_o == '0));

endmodule

// File: rtl/lkd_decimator.sv
module lkd_decimator #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned DECIM = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             eval_o,
  output logic [CNT_W-1:0] width_o
);

  localparam int unsigned DW = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [DW-1:0] LAST = DW'(DECIM - 1);

  logic [DW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      phase   <= '0;
      eval_o  <= 1'b0;
      width_o <= '0;
    end else begin
      eval_o <= 1'b0;
      if (valid_i) begin
        if (phase == LAST) begin
          phase   <= '0;
          eval_o  <= 1'b1;
          width_o <= width_i;
        end else begin
          phase <= phase + DW'(1);
        end
      end
    end
  end

  // R1: an evaluation is a single isolated pulse
  p_eval_isolated_r1: assert property (@(posedge clk) disable iff (rst)
    eval_o |=> !eval_o);

endmodule

// File: rtl/lkd_hyst_filter.sv
module lkd_hyst_filter #(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned GOOD_NEEDED = 4,
  parameter int unsigned LOSS_THR    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             eval_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] acq_thr_i,
  output logic             lock_o
);

  localparam int unsigned GW = $clog2(GOOD_NEEDED + 1);
  localparam logic [GW-1:0] NEED = GW'(GOOD_NEEDED);
  localparam logic [CNT_W-1:0] LOSS_V = CNT_W'(LOSS_THR);

  logic [GW-1:0] good_cnt;
  logic          good_w;
  logic          bad_w;
  logic [GW-1:0] good_next;

  assign good_w    = width_i < acq_thr_i;
  assign bad_w     = width_i > LOSS_V;
  assign good_next = (good_cnt == NEED) ? NEED : good_cnt + GW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      good_cnt <= '0;
      lock_o   <= 1'b0;
    end else if (eval_i) begin
      if (good_w) begin
        good_cnt <= good_next;
        if (good_next == NEED) lock_o <= 1'b1;
      end else begin
        good_cnt <= '0;
        if (bad_w) lock_o <= 1'b0;
      end
    end
  end

  // R2: lock only rises on an evaluated good comparison
  p_rise_on_good_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> ($past(eval_i) && $past(good_w)));

  // R4: lock only falls via clear or an evaluated width above the loss limit
  p_fall_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> ($past(clr_i) || ($past(eval_i) && $past(width_i) > LOSS_V)));

  // R5: good run counter stays bounded
  p_good_bound_r5: assert property (@(posedge clk) disable iff (rst)
    good_cnt <= NEED);

  // R8: clear wipes lock history
  p_clear_wipes_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!lock_o && good_cnt == '0));

endmodule

// File: rtl/pll_lock_filter.sv
module pll_lock_filter
  import lkd_pkg::*;
#(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned DECIM       = 64,
  parameter int unsigned GOOD_NEEDED = 4,
  parameter int unsigned ACQ_THR_HI  = 5,
  parameter int unsigned ACQ_THR_LO  = 10,
  parameter int unsigned LOSS_THR    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_div,
  input  logic fb_div,
  input  logic ld_enable,
  input  logic power_down,
  input  logic band_high,
  output logic lock_out
);

  logic [CH_NUM-1:0] lvl;
  logic [CH_NUM-1:0] rise;
  logic              meas_valid;
  logic [CNT_W-1:0]  meas_width;
  logic              eval;
  logic [CNT_W-1:0]  eval_width;
  logic [CNT_W-1:0]  acq_thr;
  logic              lock_state;

  assign lvl[CH_REF] = ref_div;
  assign lvl[CH_FB]  = fb_div;
  assign acq_thr     = band_high ? CNT_W'(ACQ_THR_HI) : CNT_W'(ACQ_THR_LO);

  lkd_edge_sync #(
    .CHANNELS   (CH_NUM),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (lvl),
    .rise_o(rise)
  );

  lkd_phase_meter #(
    .CNT_W(CNT_W)
  ) u_meter (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (power_down),
    .rise_ref_i(rise[CH_REF]),
    .rise_fb_i (rise[CH_FB]),
    .valid_o   (meas_valid),
    .width_o   (meas_width)
  );

  lkd_decimator #(
    .CNT_W(CNT_W),
    .DECIM(DECIM)
  ) u_decim (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (power_down),
    .valid_i(meas_valid),
    .width_i(meas_width),
    .eval_o (eval),
    .width_o(eval_width)
  );

  lkd_hyst_filter #(
    .CNT_W      (CNT_W),
    .GOOD_NEEDED(GOOD_NEEDED),
    .LOSS_THR   (LOSS_THR)
  ) u_filt (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (power_down),
    .eval_i   (eval),
    .width_i  (eval_width),
    .acq_thr_i(acq_thr),
    .lock_o   (lock_state)
  );

  always_ff @(posedge clk) begin
    if (rst) lock_out <= 1'b0;
    else     lock_out <= lock_state & ld_enable & ~power_down;
  end

  // R7: disabled output is low one cycle later
  p_out_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !ld_enable |=> !lock_out);

  // R8: power-down output is low one cycle later
  p_pd_low_r8: assert property (@(posedge clk) disable iff (rst)
    power_down |=> !lock_out);

endmodule

// File: tb/pll_lock_filter_tb.sv
module pll_lock_filter_tb;

  localparam int PERIOD = 32;
  localparam int HIGH   = 16;
  localparam int WD_LIM = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_div = 1'b0;
  logic fb_div = 1'b0;
  logic ld_enable = 1'b1;
  logic power_down = 1'b0;
  logic band_high = 1'b1;
  logic lock_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pll_lock_filter u_dut (
    .clk       (clk),
    .rst       (rst),
    .ref_div   (ref_div),
    .fb_div    (fb_div),
    .ld_enable (ld_enable),
    .power_down(power_down),
    .band_high (band_high),
    .lock_out  (lock_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIM) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WD_LIM);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input logic got, input logic exp, input string tag);
    checks = checks + 1;
    if (got !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  // n pairs; lag edge d cycles after lead; fb_first swaps roles; fb_on=0 removes feedback
  task automatic run_pairs(input int n, input int d, input bit fb_first, input bit fb_on);
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c < PERIOD; c++) begin
        @(negedge clk);
        if (fb_first) begin
          fb_div  = fb_on && (c < HIGH);
          ref_div = (c >= d) && (c < d + HIGH);
        end else begin
          ref_div = (c < HIGH);
          fb_div  = fb_on && (c >= d) && (c < d + HIGH);
        end
      end
    end
  endtask

  task automatic pd_pulse();
    @(negedge clk);
    power_down = 1'b1;
    ref_div = 1'b0;
    fb_div = 1'b0;
    repeat (4) @(negedge clk);
    check(lock_out, 1'b0, "R8 output low in power-down");
    power_down = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(lock_out, 1'b0, "R9 reset state");

    // R2: high band, width 2
    band_high = 1'b1;
    run_pairs(192, 2, 0, 1);
    check(lock_out, 1'b0, "R2 low after three good comparisons");
    run_pairs(64, 2, 0, 1);
    check(lock_out, 1'b1, "R2 high after four good comparisons");
    // R1 / R4: 63 bad pairs ignored, 64th drops
    run_pairs(63, 11, 0, 1);
    check(lock_out, 1'b1, "R1 non-evaluated bad pairs ignored");
    run_pairs(1, 11, 0, 1);
    check(lock_out, 1'b0, "R4 single bad comparison drops lock");

    // R3 boundary below, R4 boundary kept, R7 enable gating, R8 clearing
    pd_pulse();
    run_pairs(256, 4, 0, 1);
    check(lock_out, 1'b1, "R3 width 4 good in high band");
    run_pairs(64, 10, 0, 1);
    check(lock_out, 1'b1, "R4 width 10 keeps lock");
    @(negedge clk);
    ld_enable = 1'b0;
    repeat (2) @(negedge clk);
    check(lock_out, 1'b0, "R7 disabled output low");
    ld_enable = 1'b1;
    repeat (2) @(negedge clk);
    check(lock_out, 1'b1, "R7 lock state kept while disabled");
    pd_pulse();
    run_pairs(192, 4, 0, 1);
    check(lock_out, 1'b0, "R8 history cleared by power-down");
    run_pairs(64, 4, 0, 1);
    check(lock_out, 1'b1, "R8 relock after four fresh comparisons");

    // R3 equal-to-threshold cases and R6 feedback leading
    pd_pulse();
    run_pairs(320, 5, 0, 1);
    check(lock_out, 1'b0, "R3 width 5 not good in high band");
    pd_pulse();
    band_high = 1'b0;
    run_pairs(256, 9, 1, 1);
    check(lock_out, 1'b1, "R3 R6 width 9 feedback-leading good in low band");
    pd_pulse();
    run_pairs(320, 10, 0, 1);
    check(lock_out, 1'b0, "R3 width 10 not good in low band");

    // R5: a mid-range width resets the run
    pd_pulse();
    band_high = 1'b1;
    run_pairs(192, 3, 0, 1);
    run_pairs(64, 7, 0, 1);
    run_pairs(192, 3, 0, 1);
    check(lock_out, 1'b0, "R5 run restarted by mid-range width");
    run_pairs(64, 3, 0, 1);
    check(lock_out, 1'b1, "R5 lock after four fresh goods");

    // R6: coincident edges, then missing feedback
    pd_pulse();
    run_pairs(256, 0, 0, 1);
    check(lock_out, 1'b1, "R6 coincident edges measure zero");
    run_pairs(66, 0, 0, 0);
    check(lock_out, 1'b0, "R6 missing feedback edge counted bad");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule